// File: doc/BRIEF.md
# GPIO Port with Edge-Sensed Interrupts

This block is a 32-pin general-purpose I/O port. Software reaches it through a simple register bus. Each access takes one cycle: the address and write data are presented with a write enable, and read data comes back combinationally from the addressed register. For every pin, a direction bit chooses between driving the stored data value and sampling the pad. Sampled inputs pass through a synchroniser. The synchronised inputs are compared with their previous values to find rising and falling edges.

Each edge that matches the pin's sense setting sets a sticky event bit. Software clears an event bit by writing a 1 to it. A mask register selects which pending events reach the single interrupt output. Pin 0 is the most significant bit of every register.

A build option chooses the sense format:
- **Basic:** each pin has one sense bit, choosing falling-only or both edges.
- **Extended:** each pin has a 2-bit sense code, and the codes are spread over two configuration words. In this variant the four highest-numbered pins can only be inputs.

Top module: `gpio_irq_port`

## Requirements
- R1: A direction bit of 1 makes the pin an output. `pinOe` equals the direction register, and `pinOut` equals the data register. A write to the direction word at 0x00 takes effect on the next clock edge.
- R2: Pin n corresponds to register bit 31−n in every register, so an edge on pin 0 sets event bit 31.
- R3: Writing the event word at 0x0C clears each event bit written with 1. Bits written with 0 keep their value.
- R4: `irqOut` is 1 exactly when some bit is set in both the event word and the mask word at 0x10.
- R5: In basic mode, sense word bit b (at 0x14) set to 1 latches only falling edges of that pin. Set to 0, it latches both edges.
- R6: In extended mode, pin n uses a 2-bit code. Pins 0–15 take it from the word at 0x14 and pins 16–31 from the word at 0x18. The code sits at bits [(15−(n mod 16))·2 +: 2]. Code 00 selects both edges, 01 rising only, 10 falling only, and 11 latches nothing.
- R7: In extended mode, direction bits 3..0 (pins 28–31) ignore writes, read as 0, and keep `pinOe` low.
- R8: The register map is:
  - 0x00: direction
  - 0x04: open-drain (stored and read back only)
  - 0x08: data
  - 0x0C: event
  - 0x10: mask
  - 0x14: first sense word
  - 0x18: second sense word (extended mode only)

  Every other address reads 0 and ignores writes. This includes 0x1C, any address whose two low bits are not 00, and 0x18 in basic mode.
- R9: Reading 0x08 returns the data register bit for output pins and the synchronised pin value for input pins.
- R10: A pin change first shows in a 0x08 read after the second rising clock edge. It sets its event bit at the third rising edge.
- R11: After reset, every register reads 0, `pinOe` is 0 and `irqOut` is 0.
- R12: When an edge latches on the same clock edge as a write of 1 to that event bit, the event bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register |
| busWe | input | 1 | Write enable for this cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register |
| pinIn | input | 32 | Pad input levels |
| pinOut | output | 32 | Pad output levels |
| pinOe | output | 32 | Pad output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Some behaviours are checked on every cycle by the assertions:
- writes to the event word clear the written bits when no edge coincides;
- a detected edge always leaves its event bit set on the next cycle, even during a clear;
- a direction write lands in the output enables, with the input-only pins removed;
- a zero mask silences the interrupt;
- at most one register write strobe is active at a time.

Other behaviours need the bench scenarios: the mapping from pin number to bit and sense field, the result of each sense code on each edge direction, the delay of the synchroniser, the mixed data read-back, and the decoding of unmapped and misaligned addresses. The bench covers these with sweeps over every pin and every code in both build variants.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int PIN_COUNT  = 32;
  localparam int REG_ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_DIR    = 3'd0,
    SEL_OD     = 3'd1,
    SEL_DATA   = 3'd2,
    SEL_EVT    = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_SENSE1 = 3'd5,
    SEL_SENSE2 = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrOd;
    logic    wrData;
    logic    wrEvt;
    logic    wrMask;
    logic    wrSense1;
    logic    wrSense2;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter bit EXT_SENSE = 1'b0
) (
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  output ctrlStrobes_t          strobes
);

  logic [2:0] wordIdx;
  logic       aligned;
  regSel_e    sel;

  assign wordIdx = busAddr[4:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      unique case (wordIdx)
        3'd0:    sel = SEL_DIR;
        3'd1:    sel = SEL_OD;
        3'd2:    sel = SEL_DATA;
        3'd3:    sel = SEL_EVT;
        3'd4:    sel = SEL_MASK;
        3'd5:    sel = SEL_SENSE1;
        3'd6:    sel = EXT_SENSE ? SEL_SENSE2 : SEL_NONE;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobes.rdSel    = sel;
    strobes.wrDir    = busWe && (sel == SEL_DIR);
    strobes.wrOd     = busWe && (sel == SEL_OD);
    strobes.wrData   = busWe && (sel == SEL_DATA);
    strobes.wrEvt    = busWe && (sel == SEL_EVT);
    strobes.wrMask   = busWe && (sel == SEL_MASK);
    strobes.wrSense1 = busWe && (sel == SEL_SENSE1);
    strobes.wrSense2 = busWe && (sel == SEL_SENSE2);
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter bit EXT_SENSE   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] rdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  localparam int HALF = PIN_COUNT / 2;
  localparam logic [PIN_COUNT-1:0] DIR_MASK =
    EXT_SENSE ? {{(PIN_COUNT-4){1'b1}}, 4'b0000} : {PIN_COUNT{1'b1}};

  logic [PIN_COUNT-1:0] dirReg, odReg, dataReg, evtReg, maskReg;
  logic [PIN_COUNT-1:0] sense1Reg, sense2Reg;
  logic [PIN_COUNT-1:0] syncVal, prevVal, hit, clrBits;

  gpio_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (pinIn),
    .q    (syncVal)
  );

  for (genvar b = 0; b < PIN_COUNT; b++) begin : g_bit
    logic rise, fall;
    assign rise = syncVal[b] & ~prevVal[b];
    assign fall = ~syncVal[b] & prevVal[b];
    if (EXT_SENSE) begin : g_ext
      logic [1:0] code;
      if (b >= HALF) begin : g_hi
        assign code = sense1Reg[(b-HALF)*2 +: 2];
      end else begin : g_lo
        assign code = sense2Reg[b*2 +: 2];
      end
      assign hit[b] = (code == 2'b00) ? (rise | fall) :
                      (code == 2'b01) ? rise :
                      (code == 2'b10) ? fall : 1'b0;
    end else begin : g_basic
      assign hit[b] = sense1Reg[b] ? fall : (rise | fall);
    end
  end

  assign clrBits = strobes.wrEvt ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg    <= '0;
      odReg     <= '0;
      dataReg   <= '0;
      evtReg    <= '0;
      maskReg   <= '0;
      sense1Reg <= '0;
      sense2Reg <= '0;
      prevVal   <= '0;
    end else begin
      prevVal <= syncVal;
      evtReg  <= (evtReg & ~clrBits) | hit;
      if (strobes.wrDir)    dirReg    <= wdata & DIR_MASK;
      if (strobes.wrOd)     odReg     <= wdata;
      if (strobes.wrData)   dataReg   <= wdata;
      if (strobes.wrMask)   maskReg   <= wdata;
      if (strobes.wrSense1) sense1Reg <= wdata;
      if (strobes.wrSense2) sense2Reg <= wdata;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_DIR:    rdata = dirReg;
      SEL_OD:     rdata = odReg;
      SEL_DATA:   rdata = (dataReg & dirReg) | (syncVal & ~dirReg);
      SEL_EVT:    rdata = evtReg;
      SEL_MASK:   rdata = maskReg;
      SEL_SENSE1: rdata = sense1Reg;
      SEL_SENSE2: rdata = sense2Reg;
      default:    rdata = '0;
    endcase
  end

  assign pinOut = dataReg;
  assign pinOe  = dirReg;
  assign irqOut = |(evtReg & maskReg);

  // R3
  evt_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEvt && (hit == '0)) |=> ((evtReg & $past(wdata)) == '0));

  // R12
  evt_new_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit != '0) |=> ((evtReg & $past(hit)) == $past(hit)));

  // R4
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrMask && (wdata == '0)) |=> !irqOut);

  // R1
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDir |=> (pinOe == ($past(wdata) & DIR_MASK)));

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDir, strobes.wrOd, strobes.wrData, strobes.wrEvt,
              strobes.wrMask, strobes.wrSense1, strobes.wrSense2}));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter bit EXT_SENSE   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic [PIN_COUNT-1:0]  busWdata,
  output logic [PIN_COUNT-1:0]  busRdata,
  input  logic [PIN_COUNT-1:0]  pinIn,
  output logic [PIN_COUNT-1:0]  pinOut,
  output logic [PIN_COUNT-1:0]  pinOe,
  output logic                  irqOut
);

  ctrlStrobes_t strobes;

  gpio_irq_ctrl #(.EXT_SENSE(EXT_SENSE)) i_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_irq_datapath #(.EXT_SENSE(EXT_SENSE), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/100ps
module test_gpio_irq_port;

  localparam logic [4:0] A_DIR = 5'h00, A_OD = 5'h04, A_DATA = 5'h08, A_EVT = 5'h0C,
                         A_MASK = 5'h10, A_S1 = 5'h14, A_S2 = 5'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] pinIn = '0;
  logic [31:0] rdB, rdE, outB, outE, oeB, oeE;
  logic        irqB, irqE;
  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.EXT_SENSE(1'b0)) i_gpio_irq_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdB), .pinIn(pinIn), .pinOut(outB), .pinOe(oeB), .irqOut(irqB));

  gpio_irq_port #(.EXT_SENSE(1'b1)) i_gpio_irq_port_ext (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdE), .pinIn(pinIn), .pinOut(outE), .pinOe(oeE), .irqOut(irqE));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    tick();
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] vb, output logic [31:0] ve);
    busAddr = a;
    #0.2;
    vb = rdB; ve = rdE;
  endtask

  function automatic int fieldShift(input int n);
    return (15 - (n % 16)) * 2;
  endfunction

  initial begin
    logic [31:0] vb, ve;
    tick(3);
    rstN = 1'b1;

    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), vb, ve);
      chk("R11 basic reg", vb, 32'h0);
      chk("R11 ext reg", ve, 32'h0);
    end
    chk("R11 oe", oeB | oeE, 32'h0);
    chk("R11 irq", {30'h0, irqB, irqE}, 32'h0);

    // R1, R9, R10 direction and data
    wr(A_DIR, 32'hFFFF0000);
    wr(A_DATA, 32'h12345678);
    chk("R1 pinOe", oeB, 32'hFFFF0000);
    chk("R1 pinOut", outB, 32'h12345678);
    pinIn = 32'h0000ABCD;
    tick();
    rd(A_DATA, vb, ve);
    chk("R10 data after one edge", vb, 32'h12340000);
    tick();
    rd(A_DATA, vb, ve);
    chk("R9 data mix basic", vb, 32'h1234ABCD);
    chk("R9 data mix ext", ve, 32'h1234ABCD);

    // R7 input-only pins in extended mode
    wr(A_DIR, 32'hFFFFFFFF);
    rd(A_DIR, vb, ve);
    chk("R7 basic dir", vb, 32'hFFFFFFFF);
    chk("R7 ext dir", ve, 32'hFFFFFFF0);
    chk("R7 ext oe", oeE, 32'hFFFFFFF0);
    wr(A_DIR, 32'h0);
    pinIn = '0;
    tick(3);
    wr(A_EVT, 32'hFFFFFFFF);

    // R8 map
    wr(A_OD, 32'hDEADBEEF);
    rd(A_OD, vb, ve);
    chk("R8 od basic", vb, 32'hDEADBEEF);
    chk("R8 od ext", ve, 32'hDEADBEEF);
    wr(5'h1C, 32'hFFFFFFFF);
    rd(5'h1C, vb, ve);
    chk("R8 0x1C", vb | ve, 32'h0);
    wr(5'h11, 32'hFFFFFFFF);
    rd(A_MASK, vb, ve);
    chk("R8 misaligned write", vb | ve, 32'h0);
    rd(5'h05, vb, ve);
    chk("R8 misaligned read", vb | ve, 32'h0);
    wr(A_S2, 32'h5A5A5A5A);
    rd(A_S2, vb, ve);
    chk("R8 sense2 basic", vb, 32'h0);
    chk("R8 sense2 ext", ve, 32'h5A5A5A5A);
    wr(A_S2, 32'h0);

    // R2, R3, R10 pin sweep, both edges
    wr(A_MASK, 32'hFFFFFFFF);
    for (int n = 0; n < 32; n++) begin
      logic [31:0] bitv;
      bitv = 32'h1 << (31 - n);
      pinIn = bitv;
      tick(2);
      rd(A_EVT, vb, ve);
      chk("R10 no event before third edge", vb | ve, 32'h0);
      tick();
      rd(A_EVT, vb, ve);
      chk("R2 basic event bit", vb, bitv);
      chk("R2 ext event bit", ve, bitv);
      chk("R4 irq on", {30'h0, irqB, irqE}, 32'h3);
      pinIn = '0;
      tick(3);
      wr(A_EVT, ~bitv);
      rd(A_EVT, vb, ve);
      chk("R3 zero bits keep", vb, bitv);
      wr(A_EVT, bitv);
      rd(A_EVT, vb, ve);
      chk("R3 clear basic", vb, 32'h0);
      chk("R3 clear ext", ve, 32'h0);
    end

    // R5 basic falling-only and R6 code 11
    wr(A_S1, 32'hFFFFFFFF);
    wr(A_S2, 32'hFFFFFFFF);
    pinIn = 32'hFFFFFFFF;
    tick(3);
    rd(A_EVT, vb, ve);
    chk("R5 rising ignored", vb, 32'h0);
    chk("R6 code 11 rising", ve, 32'h0);
    pinIn = '0;
    tick(3);
    rd(A_EVT, vb, ve);
    chk("R5 falling latched", vb, 32'hFFFFFFFF);
    chk("R6 code 11 falling", ve, 32'h0);
    wr(A_EVT, 32'hFFFFFFFF);
    wr(A_S1, 32'hAAAAAAAA);
    pinIn = 32'hFFFFFFFF;
    tick(3);
    rd(A_EVT, vb, ve);
    chk("R5 mixed sense rising", vb, 32'h55555555);
    pinIn = '0;
    tick(3);
    wr(A_EVT, 32'hFFFFFFFF);

    // R6 extended code sweep over every pin
    for (int code = 0; code < 4; code++) begin
      for (int n = 0; n < 32; n++) begin
        logic [31:0] s1, s2, bitv, expR, expF;
        int sh;
        sh = fieldShift(n);
        s1 = 32'hFFFFFFFF; s2 = 32'hFFFFFFFF;
        if (n < 16) s1 = (s1 & ~(32'h3 << sh)) | (32'(code) << sh);
        else        s2 = (s2 & ~(32'h3 << sh)) | (32'(code) << sh);
        bitv = 32'h1 << (31 - n);
        expR = (code == 0 || code == 1) ? bitv : 32'h0;
        expF = (code == 0 || code == 2) ? bitv : 32'h0;
        wr(A_S1, s1);
        wr(A_S2, s2);
        pinIn = bitv;
        tick(3);
        rd(A_EVT, vb, ve);
        chk("R6 rising", ve, expR);
        wr(A_EVT, 32'hFFFFFFFF);
        pinIn = '0;
        tick(3);
        rd(A_EVT, vb, ve);
        chk("R6 falling", ve, expF);
        wr(A_EVT, 32'hFFFFFFFF);
      end
    end

    // R4 masking
    wr(A_S1, 32'h0);
    wr(A_S2, 32'h0);
    wr(A_MASK, 32'h0);
    pinIn = 32'hFFFFFFFF;
    tick(3);
    chk("R4 all masked", {31'h0, irqB}, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr(A_MASK, 32'h1 << b);
      chk("R4 single mask", {31'h0, irqB}, 32'h1);
    end
    wr(A_MASK, 32'h00010000);
    wr(A_EVT, 32'h00010000);
    chk("R4 masked event cleared", {31'h0, irqB}, 32'h0);
    pinIn = '0;
    tick(3);
    wr(A_EVT, 32'hFFFFFFFF);

    // R12 edge and clear on the same clock edge
    pinIn = 32'h80000000;
    tick(2);
    wr(A_EVT, 32'hFFFFFFFF);
    rd(A_EVT, vb, ve);
    chk("R12 new event wins basic", vb, 32'h80000000);
    chk("R12 new event wins ext", ve, 32'h80000000);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #900000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule